// File: doc/BRIEF.md
# Heartbeat Watchdog with Selectable Long Timeout

This block watches a heartbeat line that a processor toggles while its software runs normally. Each falling edge on the heartbeat restarts an internal cycle counter. If the counter reaches the selected timeout before the next falling edge, the block raises a one-clock fault pulse. A separate reset generator turns that pulse into a system reset.

The timeout is a parameter given in clock cycles. A mode input can multiply it by 128 while the block runs, for phases such as boot or firmware update when the processor services the heartbeat far less often. Any change on that mode input restarts the count. The heartbeat and mode lines come from outside the clock domain, so both pass through synchronizers before edges are detected. While the system reset input is high the counter stays at zero, and counting starts again on the first clock after it falls. A disable input turns the watchdog off.

The current count is brought out as a status value so software and test equipment can see how close the timer is to expiring.

Top module: `wdog_ext_timer`

## Requirements
- R1: While `rst_ni` is low, `fault_o` is 0 and `count_o` is 0.
- R2: In base mode (`mode_ext_i` low) with no heartbeat edge, `fault_o` is 1 after exactly `BASE_CYCLES` rising clock edges counted from the first edge that samples `sys_rst_i` low, and 0 one edge earlier.
- R3: In extended mode (`mode_ext_i` high), the same timeout is exactly 128 × `BASE_CYCLES` edges.
- R4: A falling edge on `kick_i` clears the counter. With `SYNC_STAGES` = 2, `count_o` reads 0 after the third rising edge that follows the fall. Falling edges spaced closer than the timeout never produce a fault.
- R5: A rising edge on `kick_i` has no effect, and the counter keeps incrementing by one per clock.
- R6: Any transition of `mode_ext_i`, in either direction, clears the counter, with the same latency as R4.
- R7: While `sys_rst_i` is high, `count_o` is held at 0 and `fault_o` stays 0. Counting resumes on the first edge at which it is low.
- R8: While `dis_i` is high, `fault_o` never asserts and `count_o` stays 0. When `dis_i` is released, counting starts again from 0.
- R9: `fault_o` is high for exactly one clock. `count_o` is 0 in the fault cycle and in the cycle after it. Without heartbeat edges, faults repeat every `BASE_CYCLES` + 1 edges in base mode.
- R10: A low pulse on `kick_i` lasting a single clock period counts as a valid falling edge.
- R11: If a heartbeat clear and a timeout fall on the same edge, the clear wins: no fault is raised and the counter returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the block's registers |
| sys_rst_i | input | 1 | System reset status; holds the counter clear while high |
| dis_i | input | 1 | Disables the watchdog while high (synchronous level) |
| mode_ext_i | input | 1 | Timeout select: 0 base, 1 base × 128 (asynchronous) |
| kick_i | input | 1 | Heartbeat from the processor; falling edge services the timer (asynchronous) |
| fault_o | output | 1 | One-cycle pulse on timeout |
| count_o | output | CNT_W | Current counter value |

## Verification
Two events can land on the same clock edge: the counter reaching its last value before a timeout, and a heartbeat fall arriving through the synchronizer and edge register. The test releases system reset, then drives the heartbeat low exactly `BASE_CYCLES` − 3 edges later. This aligns the clear with the edge that would otherwise produce the fault. The test passes if no fault pulse appears over that window and the count reads zero afterwards. A separate scenario places an edge one cycle too late and checks that the timeout pulse still appears.

// File: rtl/wdog_ext_pkg.sv
package wdog_ext_pkg;
    localparam int EXT_FACTOR = 128;

    typedef enum logic {
        TMO_BASE = 1'b0,
        TMO_LONG = 1'b1
    } tmo_sel_e;
endpackage

// File: rtl/wdog_ext_sync.sv
module wdog_ext_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
        else         chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/wdog_ext_edge.sv
module wdog_ext_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic kick_s_i,
    input  logic mode_s_i,
    output logic kick_fall_o,
    output logic mode_chg_o
);
    typedef struct packed {
        logic kick;
        logic mode;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.kick = kick_s_i;
        prev_d.mode = mode_s_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= '{kick: 1'b1, mode: 1'b0};
        else         prev_q <= prev_d;
    end

    assign kick_fall_o = prev_q.kick & ~kick_s_i;
    assign mode_chg_o  = prev_q.mode ^ mode_s_i;
endmodule

// File: rtl/wdog_ext_core.sv
module wdog_ext_core
    import wdog_ext_pkg::*;
#(
    parameter int BASE_CYCLES = 1000,
    parameter int CNT_W       = $clog2(BASE_CYCLES * EXT_FACTOR)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             hold_i,
    input  logic             restart_i,
    input  tmo_sel_e         sel_i,
    output logic             fault_o,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] LAST_BASE = CNT_W'(BASE_CYCLES - 1);
    localparam logic [CNT_W-1:0] LAST_LONG = CNT_W'(BASE_CYCLES * EXT_FACTOR - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             fault;
    } core_t;

    core_t            st_d, st_q;
    logic [CNT_W-1:0] last_val;

    always_comb begin
        last_val = (sel_i == TMO_LONG) ? LAST_LONG : LAST_BASE;
        st_d     = st_q;
        if (hold_i || restart_i || st_q.fault) begin
            st_d.cnt   = '0;
            st_d.fault = 1'b0;
        end else if (st_q.cnt == last_val) begin
            st_d.cnt   = '0;
            st_d.fault = 1'b1;
        end else begin
            st_d.cnt   = st_q.cnt + CNT_W'(1);
            st_d.fault = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign fault_o = st_q.fault;
    assign count_o = st_q.cnt;
endmodule

// File: rtl/wdog_ext_timer.sv
module wdog_ext_timer
    import wdog_ext_pkg::*;
#(
    parameter int BASE_CYCLES = 1000,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = $clog2(BASE_CYCLES * EXT_FACTOR)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             sys_rst_i,
    input  logic             dis_i,
    input  logic             mode_ext_i,
    input  logic             kick_i,
    output logic             fault_o,
    output logic [CNT_W-1:0] count_o
);
    logic     kick_s, mode_s, kick_fall, mode_chg;
    tmo_sel_e sel;

    wdog_ext_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_kick (
        .clk_i(clk_i), .rst_ni(rst_ni), .d_i(kick_i), .q_o(kick_s)
    );

    wdog_ext_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mode (
        .clk_i(clk_i), .rst_ni(rst_ni), .d_i(mode_ext_i), .q_o(mode_s)
    );

    wdog_ext_edge u_edge (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .kick_s_i(kick_s), .mode_s_i(mode_s),
        .kick_fall_o(kick_fall), .mode_chg_o(mode_chg)
    );

    assign sel = mode_s ? TMO_LONG : TMO_BASE;

    wdog_ext_core #(.BASE_CYCLES(BASE_CYCLES), .CNT_W(CNT_W)) u_core (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .hold_i(sys_rst_i | dis_i),
        .restart_i(kick_fall | mode_chg),
        .sel_i(sel),
        .fault_o(fault_o),
        .count_o(count_o)
    );
endmodule

// File: rtl/wdog_ext_timer_chk.sv
module wdog_ext_timer_chk #(
    parameter int CNT_W    = 8,
    parameter int LAST_MAX = 100
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             sys_rst_i,
    input logic             dis_i,
    input logic             fault_o,
    input logic [CNT_W-1:0] count_o
);
    // R9: the pulse lasts a single clock
    a_r9_fault_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o |=> !fault_o);

    // R9: the counter stays at zero in the clock after a pulse
    a_r9_zero_after_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o |=> (count_o == '0));

    // R8: a disabled watchdog raises no fault and holds the count at zero
    a_r8_disable_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dis_i |=> (!fault_o && count_o == '0));

    // R7: system reset holds the counter clear
    a_r7_sysrst_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sys_rst_i |=> (!fault_o && count_o == '0));

    // R5: a nonzero count always arrived by a single increment
    a_r5_count_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (count_o != '0) |-> (count_o == $past(count_o) + CNT_W'(1)));

    // R3: the count never passes the longest timeout
    a_r3_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        count_o <= CNT_W'(LAST_MAX));
endmodule

bind wdog_ext_timer wdog_ext_timer_chk #(
    .CNT_W(CNT_W),
    .LAST_MAX(BASE_CYCLES * wdog_ext_pkg::EXT_FACTOR - 1)
) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .sys_rst_i(sys_rst_i), .dis_i(dis_i),
    .fault_o(fault_o), .count_o(count_o)
);

// File: tb/wdog_ext_timer_tb.sv
module wdog_ext_timer_tb;
    localparam int BASE  = 16;
    localparam int LONG  = BASE * 128;
    localparam int CW    = $clog2(LONG);

    logic          clk = 1'b0;
    logic          rst_ni = 1'b0;
    logic          sys_rst = 1'b1;
    logic          dis = 1'b0;
    logic          mode = 1'b0;
    logic          kick = 1'b1;
    logic          fault;
    logic [CW-1:0] count;

    int n_chk = 0;
    int n_fail = 0;
    int fault_seen = 0;
    bit done = 0;

    always #2 clk = ~clk;

    wdog_ext_timer #(.BASE_CYCLES(BASE), .SYNC_STAGES(2), .CNT_W(CW)) u_dut (
        .clk_i(clk), .rst_ni(rst_ni), .sys_rst_i(sys_rst), .dis_i(dis),
        .mode_ext_i(mode), .kick_i(kick), .fault_o(fault), .count_o(count)
    );

    always @(posedge clk) begin
        #1;
        if (fault === 1'b1) fault_seen++;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic adv(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic restart(input logic m);
        sys_rst = 1'b1; kick = 1'b1; dis = 1'b0; mode = m;
        adv(6);
        sys_rst = 1'b0;
    endtask

    task automatic t_reset_state;
        adv(3);
        chk(fault == 1'b0, "R1 fault", fault, 0);
        chk(count == '0, "R1 count", count, 0);
        rst_ni = 1'b1;
        adv(2);
    endtask

    task automatic t_base_timeout;
        restart(1'b0);
        adv(BASE - 1);
        chk(fault == 1'b0, "R2 early", fault, 0);
        adv(1);
        chk(fault == 1'b1, "R2 timeout", fault, 1);
        chk(count == '0, "R9 count in fault cycle", count, 0);
        adv(1);
        chk(fault == 1'b0, "R9 single cycle", fault, 0);
        chk(count == '0, "R9 count after fault", count, 0);
        adv(1);
        chk(count == 1, "R9 counting resumes", count, 1);
        adv(BASE - 2);
        chk(fault == 1'b0, "R9 repeat early", fault, 0);
        adv(1);
        chk(fault == 1'b1, "R9 repeat period", fault, 1);
    endtask

    task automatic t_ext_timeout;
        restart(1'b1);
        adv(LONG - 1);
        chk(fault == 1'b0, "R3 early", fault, 0);
        adv(1);
        chk(fault == 1'b1, "R3 long timeout", fault, 1);
    endtask

    task automatic t_kick_and_rise;
        restart(1'b0);
        adv(6);
        kick = 1'b0;
        adv(2);
        chk(count == 8, "R4 before clear", count, 8);
        adv(1);
        chk(count == '0, "R4 fall clears", count, 0);
        adv(2);
        kick = 1'b1;
        adv(3);
        chk(count == 5, "R5 rise ignored", count, 5);
    endtask

    task automatic t_periodic;
        restart(1'b0);
        fault_seen = 0;
        for (int i = 0; i < 20; i++) begin
            adv(9); kick = 1'b0; adv(1); kick = 1'b1;
        end
        chk(fault_seen == 0, "R4 serviced no fault", fault_seen, 0);
    endtask

    task automatic t_mode_clear;
        restart(1'b0);
        adv(5);
        mode = 1'b1;
        adv(3);
        chk(count == '0, "R6 rise of mode clears", count, 0);
        adv(7);
        mode = 1'b0;
        adv(2);
        chk(count == 9, "R6 before clear", count, 9);
        adv(1);
        chk(count == '0, "R6 fall of mode clears", count, 0);
    endtask

    task automatic t_sysrst_hold;
        restart(1'b0);
        adv(10);
        sys_rst = 1'b1;
        fault_seen = 0;
        adv(1);
        chk(count == '0, "R7 cleared", count, 0);
        adv(3 * BASE);
        chk(fault_seen == 0, "R7 no fault", fault_seen, 0);
        chk(count == '0, "R7 held", count, 0);
        sys_rst = 1'b0;
        adv(3);
        chk(count == 3, "R7 resume", count, 3);
    endtask

    task automatic t_disable;
        restart(1'b0);
        dis = 1'b1;
        fault_seen = 0;
        adv(6 * BASE);
        chk(fault_seen == 0, "R8 no fault", fault_seen, 0);
        chk(count == '0, "R8 count held", count, 0);
        dis = 1'b0;
        adv(4);
        chk(count == 4, "R8 restart from zero", count, 4);
    endtask

    task automatic t_short_pulse;
        restart(1'b0);
        adv(6);
        kick = 1'b0;
        adv(1);
        kick = 1'b1;
        adv(2);
        chk(count == '0, "R10 one-clock pulse", count, 0);
    endtask

    task automatic t_coincide;
        restart(1'b0);
        adv(BASE - 3);
        kick = 1'b0;
        fault_seen = 0;
        adv(3);
        chk(fault_seen == 0, "R11 clear wins", fault_seen, 0);
        chk(count == '0, "R11 count", count, 0);
        kick = 1'b1;
        restart(1'b0);
        adv(BASE - 2);
        kick = 1'b0;
        fault_seen = 0;
        adv(2);
        chk(fault_seen == 1, "R11 late edge faults", fault_seen, 1);
        kick = 1'b1;
    endtask

    initial begin
        t_reset_state();
        t_base_timeout();
        t_ext_timeout();
        t_kick_and_rise();
        t_periodic();
        t_mode_clear();
        t_sysrst_hold();
        t_disable();
        t_short_pulse();
        t_coincide();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule